// File: doc/BRIEF.md
# Remote DMA Transfer Engine

This block moves data between a host-side data port and local packet memory on host command. The host loads a start address and a byte count one byte at a time, then issues a three-bit command: read (memory to host), write (host to memory) or abort. Each time the host strobes the data port, one byte or one 16-bit word moves. The current address then steps forward and the remaining count steps down. When the count runs out, the engine returns to idle and pulses a completion flag.

In read mode the engine fetches the next memory location ahead of the host. The data port therefore already holds valid data when the host strobes it. The address stays inside a packet ring: a step that lands in the ring's stop page continues in the ring's start page at the same offset. In word mode the two bytes of each word can be swapped for big-endian hosts. An abort stops the engine at once and leaves the current address where the transfer stopped.

Top module: `rdma_engine`

## Requirements
- R1: Command code 3'b001 starts a read and 3'b010 starts a write. Codes 3'b000 and 3'b011 are ignored: busy stays low, done stays low and cur_addr is unchanged.
- R2: A configuration write with cfg_sel 0 sets the start address low byte, 1 its high byte, 2 the count low byte and 3 the count high byte. Both values are captured when a read or write command is accepted.
- R3: On command acceptance cur_addr equals the programmed start address. Each transfer then adds 1 in byte mode (word_mode=0) or 2 in word mode, and cur_addr does not change between transfers.
- R4: The count drops by the step size at each transfer. The transfer that brings it to zero ends the command: on the next cycle busy is low and done is high for exactly one cycle.
- R5: In word mode a remaining count of 1 ends the command after one more word transfer; the count never wraps.
- R6: A step whose result lies in page ring_stop (upper 8 address bits) is redirected to page ring_start with the same low 8 bits.
- R7: In read mode the memory read is issued in the cycle after the command or after a host read. port_ready rises two cycles after that edge, with host_rdata valid.
- R8: Byte mode writes host_wdata[7:0] and returns {8'h00, byte} on reads. Word mode keeps memory words little-endian ({byte at addr+1, byte at addr}); swap_bytes=1 exchanges the two bytes in both directions.
- R9: An abort (cmd[2]=1) returns the engine to idle on the next cycle without a done pulse, and cur_addr keeps its last stepped value.
- R10: A read or write command with a count of zero raises done on the next cycle, issues no memory request, and loads cur_addr with the start address.
- R11: While the engine is idle, host_rd and host_wr cause no memory request and change no memory contents.
- R12: After reset, busy, done, port_ready and mem_req are low and cur_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 2 | Selects start low/high or count low/high |
| cfg_wdata | input | 8 | Configuration byte |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code |
| word_mode | input | 1 | 1 selects 16-bit transfers |
| swap_bytes | input | 1 | 1 swaps bytes of each word |
| ring_start | input | 8 | First page of the packet ring |
| ring_stop | input | 8 | Page just past the ring |
| host_rd | input | 1 | Host data-port read strobe |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data returned to the host |
| port_ready | output | 1 | Read data valid on host_rdata |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write |
| mem_wide | output | 1 | 1 for a word access |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |
| cur_addr | output | 16 | Current transfer address |
| busy | output | 1 | A command is active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a host that strobes host_rd only while port_ready is high and host_wr only during a write command. They also assume the host never raises a data strobe in the same cycle as an abort, and that memory returns read data exactly one cycle after a read request. The bench drives every strobe from a task that first waits for the matching state. It issues aborts only on cycles with no data strobe, and its memory model answers with a fixed one-cycle latency. Transfers stay inside a two-page ring, so wrapped addresses remain within the bench memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_READY,
      ST_WRITE
   } rdma_state_e;

   localparam logic [2:0] CMD_READ  = 3'b001;
   localparam logic [2:0] CMD_WRITE = 3'b010;

   function automatic logic [15:0] swap16(input logic [15:0] w);
      return {w[7:0], w[15:8]};
   endfunction
endpackage

// File: rtl/rdma_hostregs.sv
module rdma_hostregs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  byte_count
);
   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         count_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            2'd0:    start_q[7:0]        <= cfg_wdata;
            2'd1:    start_q[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0];
            2'd2:    count_q[7:0]        <= cfg_wdata;
            default: count_q[CNT_W-1:8]  <= cfg_wdata[CNT_W-9:0];
         endcase
      end
   end

   assign start_addr = start_q;
   assign byte_count = count_q;
endmodule

// File: rtl/rdma_stepper.sv
module rdma_stepper #(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter int PAGE_W  = 8,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wide,
   input  logic [PAGE_W-1:0] ring_start,
   input  logic [PAGE_W-1:0] ring_stop,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [CNT_W-1:0]  cnt_nxt,
   output logic              last
);
   localparam int OFF_W = ADDR_W - PAGE_W;

   logic [ADDR_W-1:0] stride_a;
   logic [CNT_W-1:0]  stride_c;
   logic [ADDR_W-1:0] sum;

   assign stride_a = wide ? ADDR_W'(2) : ADDR_W'(1);
   assign stride_c = wide ? CNT_W'(2) : CNT_W'(1);
   assign sum      = addr + stride_a;

   generate
      if (WRAP_EN) begin : g_wrap
         assign addr_nxt = (sum[ADDR_W-1:OFF_W] == ring_stop)
                           ? {ring_start, sum[OFF_W-1:0]} : sum;
      end else begin : g_flat
         assign addr_nxt = sum;
      end
   endgenerate

   // saturating: an odd remainder in word mode ends the command
   assign last    = (cnt <= stride_c);
   assign cnt_nxt = last ? '0 : cnt - stride_c;
endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes #(
   parameter bit SWAP_EN = 1'b1
) (
   input  logic        wide,
   input  logic        swap,
   input  logic [15:0] wr_word,
   input  logic [15:0] rd_word,
   output logic [15:0] mem_word,
   output logic [15:0] host_word
);
   import rdma_pkg::*;

   logic [15:0] wr_ord;
   logic [15:0] rd_ord;

   generate
      if (SWAP_EN) begin : g_swap
         assign wr_ord = swap ? swap16(wr_word) : wr_word;
         assign rd_ord = swap ? swap16(rd_word) : rd_word;
      end else begin : g_noswap
         assign wr_ord = wr_word;
         assign rd_ord = rd_word;
      end
   endgenerate

   assign mem_word  = wide ? wr_ord : {8'h00, wr_word[7:0]};
   assign host_word = wide ? rd_ord : {8'h00, rd_word[7:0]};
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter int PAGE_W  = 8,
   parameter bit WRAP_EN = 1'b1,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd,
   input  logic              word_mode,
   input  logic              swap_bytes,
   input  logic [PAGE_W-1:0] ring_start,
   input  logic [PAGE_W-1:0] ring_stop,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   output logic              port_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              busy,
   output logic              done
);
   import rdma_pkg::*;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("rdma_engine: ADDR_W must lie in 9..16");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
         $error("rdma_engine: CNT_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("rdma_engine: PAGE_W must be below ADDR_W");
      end
   endgenerate

   rdma_state_e       state_q;
   logic [ADDR_W-1:0] addr_q, start_addr, addr_nxt;
   logic [CNT_W-1:0]  cnt_q, byte_count, cnt_nxt;
   logic              wide_q, swap_q, done_q, last;
   logic [15:0]       hold_q;
   logic              abort, go_read, go_write;

   rdma_hostregs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .start_addr(start_addr), .byte_count(byte_count)
   );

   rdma_stepper #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
                  .WRAP_EN(WRAP_EN)) u_step (
      .addr(addr_q), .cnt(cnt_q), .wide(wide_q), .ring_start(ring_start),
      .ring_stop(ring_stop), .addr_nxt(addr_nxt), .cnt_nxt(cnt_nxt), .last(last)
   );

   rdma_lanes #(.SWAP_EN(SWAP_EN)) u_lanes (
      .wide(wide_q), .swap(swap_q), .wr_word(host_wdata), .rd_word(hold_q),
      .mem_word(mem_wdata), .host_word(host_rdata)
   );

   assign abort    = cmd_valid && cmd[2];
   assign go_read  = cmd_valid && (cmd == CMD_READ);
   assign go_write = cmd_valid && (cmd == CMD_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cnt_q   <= '0;
         wide_q  <= 1'b0;
         swap_q  <= 1'b0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (go_read || go_write) begin
                     addr_q <= start_addr;
                     cnt_q  <= byte_count;
                     wide_q <= word_mode;
                     swap_q <= swap_bytes;
                     if (byte_count == '0)
                        done_q <= 1'b1;
                     else
                        state_q <= go_read ? ST_FETCH : ST_WRITE;
                  end
               end
               ST_FETCH: state_q <= ST_WAIT;
               ST_WAIT: begin
                  hold_q  <= mem_rdata;
                  state_q <= ST_READY;
               end
               ST_READY: begin
                  if (host_rd) begin
                     addr_q <= addr_nxt;
                     cnt_q  <= cnt_nxt;
                     if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_FETCH;
                     end
                  end
               end
               ST_WRITE: begin
                  if (host_wr) begin
                     addr_q <= addr_nxt;
                     cnt_q  <= cnt_nxt;
                     if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign port_ready = (state_q == ST_READY);
   assign cur_addr   = addr_q;
   assign mem_addr   = addr_q;
   assign mem_wide   = wide_q;
   assign mem_we     = (state_q == ST_WRITE);
   assign mem_req    = (state_q == ST_FETCH) || ((state_q == ST_WRITE) && host_wr);

   // R4
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd[2]) |=> (!busy && !done));

   // R1
   illegal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && !cmd[2] && (cmd[1] == cmd[0])) |=> (!busy && !done));

   // R7
   ready_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_ready |-> (busy && !mem_req));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && !$past(host_rd || host_wr)) |-> $stable(cur_addr));

   // R11
   idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

// File: tb/tb_rdma_engine.sv
`timescale 1ns/1ps
module tb_rdma_engine;
   localparam logic [7:0] RS = 8'h02;
   localparam logic [7:0] RE = 8'h04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd = '0;
   logic        word_mode = 1'b0, swap_bytes = 1'b0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata, mem_wdata, mem_addr, cur_addr;
   logic [15:0] mem_rdata = '0;
   logic        port_ready, mem_req, mem_we, mem_wide, busy, done;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem [0:1023];

   always #10 clk = ~clk;

   rdma_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd(cmd),
      .word_mode(word_mode), .swap_bytes(swap_bytes), .ring_start(RS),
      .ring_stop(RE), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .port_ready(port_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cur_addr(cur_addr), .busy(busy), .done(done)
   );

   // memory model, one-cycle read latency, preset during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (mem_req && mem_we) begin
         mem[mem_addr[9:0]] <= mem_wdata[7:0];
         if (mem_wide) mem[10'(mem_addr[9:0] + 10'd1)] <= mem_wdata[15:8];
      end else if (mem_req) begin
         mem_rdata <= mem_wide ? {mem[10'(mem_addr[9:0] + 10'd1)], mem[mem_addr[9:0]]}
                               : {8'h00, mem[mem_addr[9:0]]};
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] a, input bit w);
      logic [15:0] s;
      s = a + (w ? 16'd2 : 16'd1);
      if (s[15:8] == RE) s = {RS, s[7:0]};
      return s;
   endfunction

   task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prog(input logic [15:0] st, input logic [15:0] cn);
      cfg(2'd0, st[7:0]); cfg(2'd1, st[15:8]);
      cfg(2'd2, cn[7:0]); cfg(2'd3, cn[15:8]);
   endtask

   task automatic issue(input logic [2:0] c);
      cmd_valid = 1'b1; cmd = c;
      @(negedge clk);
      cmd_valid = 1'b0; cmd = '0;
   endtask

   task automatic zero_checks(input logic [15:0] st);
      // R10
      chk(done && !busy, "R10", "done after empty command", {busy, done}, 2'b01);
      chk(cur_addr == st, "R10", "address loaded", cur_addr, st);
      chk(!mem_req, "R10", "no request", mem_req, 0);
      @(negedge clk);
      chk(!done, "R4", "done one cycle", done, 0);
   endtask

   task automatic do_read(input logic [15:0] st, input logic [15:0] cn,
                          input bit w, input bit sw);
      logic [15:0] a, c, e;
      prog(st, cn);
      word_mode = w; swap_bytes = sw;
      issue(3'b001);
      if (cn == 0) begin
         zero_checks(st);
         return;
      end
      // R2 R3
      chk(busy && cur_addr == st, "R3", "start address", cur_addr, st);
      a = st; c = cn;
      while (c != 0) begin
         chk(!port_ready, "R7", "not ready at fetch", port_ready, 0);
         @(negedge clk);
         chk(!port_ready, "R7", "not ready at wait", port_ready, 0);
         @(negedge clk);
         chk(port_ready, "R7", "ready two cycles on", port_ready, 1);
         e = w ? {mem[10'(a[9:0] + 10'd1)], mem[a[9:0]]} : {8'h00, mem[a[9:0]]};
         if (w && sw) e = {e[7:0], e[15:8]};
         chk(host_rdata == e, "R8", "read data", host_rdata, e);
         chk(cur_addr == a, "R6", "read address", cur_addr, a);
         host_rd = 1'b1;
         @(negedge clk);
         host_rd = 1'b0;
         a = nxt(a, w);
         c = (c <= (w ? 16'd2 : 16'd1)) ? 16'd0 : c - (w ? 16'd2 : 16'd1);
         if (c == 0) begin
            // R4 R5
            chk(done && !busy, "R4", "read completes", {busy, done}, 2'b01);
            @(negedge clk);
            chk(!done && cur_addr == a, "R5", "final address, single pulse", cur_addr, a);
         end
      end
   endtask

   task automatic do_write(input logic [15:0] st, input logic [15:0] cn,
                           input bit w, input bit sw, input logic [15:0] seed);
      logic [15:0] a, c, d, m;
      prog(st, cn);
      word_mode = w; swap_bytes = sw;
      issue(3'b010);
      if (cn == 0) begin
         zero_checks(st);
         return;
      end
      a = st; c = cn; d = seed;
      while (c != 0) begin
         chk(cur_addr == a, "R3", "write address", cur_addr, a);
         host_wr = 1'b1; host_wdata = d;
         #1;
         chk(mem_req && mem_we && mem_addr == a, "R6", "write request", mem_addr, a);
         @(negedge clk);
         host_wr = 1'b0;
         m = (w && sw) ? {d[7:0], d[15:8]} : d;
         chk(mem[a[9:0]] == m[7:0], "R8", "low byte stored", mem[a[9:0]], m[7:0]);
         if (w)
            chk(mem[10'(a[9:0] + 10'd1)] == m[15:8], "R8", "high byte stored",
                mem[10'(a[9:0] + 10'd1)], m[15:8]);
         a = nxt(a, w);
         c = (c <= (w ? 16'd2 : 16'd1)) ? 16'd0 : c - (w ? 16'd2 : 16'd1);
         d = d + 16'h1357;
         if (c == 0) begin
            chk(done && !busy, "R4", "write completes", {busy, done}, 2'b01);
            @(negedge clk);
            chk(!done && cur_addr == a, "R5", "final address, single pulse", cur_addr, a);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] keep;
      repeat (3) @(negedge clk);
      // R12
      chk(!busy && !done && !port_ready && !mem_req, "R12", "reset outputs",
          {busy, done, port_ready, mem_req}, 0);
      chk(cur_addr == 0, "R12", "reset address", cur_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: width, swap, count 0..6
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 2; s++)
            for (int n = 0; n < 7; n++) begin
               do_read(16'h0200 + 16'(n * 16 + s * 8), 16'(n), w[0], s[0]);
               do_write(16'h0300 + 16'(n * 16 + s * 8), 16'(n), w[0], s[0],
                        16'hA1B2 + 16'(n));
            end

      // R6 wrap through the stop page
      do_read(16'h03FE, 16'd5, 1'b0, 1'b0);
      do_read(16'h03FC, 16'd8, 1'b1, 1'b1);
      do_write(16'h03FD, 16'd4, 1'b0, 1'b0, 16'h0055);
      do_write(16'h03FE, 16'd6, 1'b1, 1'b0, 16'h1234);

      // R9 abort during a read
      prog(16'h0230, 16'd8);
      word_mode = 1'b1; swap_bytes = 1'b0;
      issue(3'b001);
      @(negedge clk); @(negedge clk);
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
      @(negedge clk); @(negedge clk);
      issue(3'b100);
      chk(!busy && !done, "R9", "read abort idle", {busy, done}, 0);
      chk(cur_addr == 16'h0232, "R9", "address kept after abort", cur_addr, 16'h0232);
      @(negedge clk);
      chk(cur_addr == 16'h0232 && !done, "R9", "still kept", cur_addr, 16'h0232);

      // R9 abort during a write, code 111
      prog(16'h0280, 16'd6);
      word_mode = 1'b0;
      issue(3'b010);
      host_wr = 1'b1; host_wdata = 16'h00EE; @(negedge clk); host_wr = 1'b0;
      issue(3'b111);
      chk(!busy && !done && cur_addr == 16'h0281, "R9", "write abort", cur_addr, 16'h0281);

      // R1 ignored codes
      prog(16'h0345, 16'd3);
      issue(3'b000);
      chk(!busy && !done && cur_addr == 16'h0281, "R1", "code 000 ignored", cur_addr, 16'h0281);
      issue(3'b011);
      chk(!busy && !done && cur_addr == 16'h0281, "R1", "code 011 ignored", cur_addr, 16'h0281);

      // R11 strobes while idle
      keep = mem[10'h281];
      host_wr = 1'b1; host_wdata = 16'h5A5A; host_rd = 1'b1;
      #1;
      chk(!mem_req, "R11", "no request when idle", mem_req, 0);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      chk(mem[10'h281] == keep && cur_addr == 16'h0281, "R11", "memory untouched",
          mem[10'h281], keep);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule